// File: doc/BRIEF.md
# Rotate-XOR Sigma Shift Unit

This block is the shift unit of a hash datapath. It takes one data word and produces either a single right rotate or logical right shift of that word, or the XOR of three independently configured shifts of the same word. The second form covers the big-sigma and small-sigma functions of common hash rounds and message schedules. Fixed-amount schedule variants are obtained by tying the amount inputs to constants.

The 64-bit input is handled in one of two lane modes. In split mode the upper and lower 32-bit halves are two separate words, each shifted by its own 32-bit shifter with the same configuration, and no bit moves between halves. In wide mode the whole word goes through a separate 64-bit shifter path, because a 64-bit rotate cannot be assembled from two 32-bit rotates. The result is registered, so it appears one cycle after the input is accepted.

Top module: `sigma_rotxor_unit`

## Requirements
- R1: While rst_ni is low, valid_o and data_o are 0.
- R2: valid_o is valid_i delayed by one clock. data_o takes the result computed from the inputs one clock after valid_i is high. When valid_i is low, data_o holds its value.
- R3: With func_i=0 (single), the result is stage 0 alone. The amounts and types of stages 1 and 2 have no effect.
- R4: With func_i=1 (triple), the result is the XOR of the outputs of stages 0, 1 and 2, all taken from the same input word.
- R5: Stage k, selected by rot_i[k], is a right rotate when that bit is 1. When the bit is 0 it is a logical right shift that fills with zeros.
- R6: With mode_i=0 (split), data_o[63:32] depends only on data_i[63:32] and data_o[31:0] depends only on data_i[31:0].
- R7: In split mode each stage uses amt_i[k][4:0], and amt_i[k][5] is ignored.
- R8: With mode_i=1 (wide), each stage shifts the full 64-bit word by the 6-bit amt_i[k].
- R9: An amount of 0 passes the word through unchanged, for both types.
- R10: A left rotate by n is obtained as a right rotate by width minus n.
- R11: Stages set to rotate by 2, 13 and 22 in split triple mode give the 32-bit big-sigma-0 of each half at once. Rotate amounts 14, 18 and 41 in wide triple mode give the 64-bit big-sigma-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Accept the inputs this cycle |
| mode_i | input | 1 | 0 = two 32-bit lanes, 1 = one 64-bit word |
| func_i | input | 1 | 0 = stage 0 only, 1 = XOR of three stages |
| amt_i | input | 3x6 | Shift amount per stage, amt_i[k] for stage k |
| rot_i | input | 3 | Per stage: 1 = rotate right, 0 = logical shift right |
| data_i | input | 64 | Input word (or two 32-bit words) |
| valid_o | output | 1 | Result valid |
| data_o | output | 64 | Registered result |

## Verification
On every cycle the assertions check the following:
- Each stage passes its word through unchanged at amount 0.
- A logical shift leaves the top bit zero.
- A rotate keeps the number of ones.
- valid_o follows valid_i, and data_o stays put when idle.
- A zero upper half in split mode gives a zero upper result.

Only the bench scenarios show the rest:
- that the exact values are correct;
- that stages 1 and 2 are ignored in single mode;
- that amount bit 5 is dropped in split mode;
- that a left rotate works through width minus n;
- the two sigma functions.

// File: rtl/sigma_pkg.sv
package sigma_pkg;
  localparam int NUM_STAGES = 3;
  typedef enum logic {MODE_SPLIT = 1'b0, MODE_WIDE = 1'b1} lane_mode_e;
  typedef enum logic {FN_SINGLE = 1'b0, FN_TRIPLE = 1'b1} func_e;
endpackage

// File: rtl/sigma_shift_stage.sv
module sigma_shift_stage #(
  parameter int W  = 32,
  parameter int AW = $clog2(W)
) (
  input  logic [W-1:0]  data_i,
  input  logic [AW-1:0] amt_i,
  input  logic          rot_i,
  output logic [W-1:0]  data_o
);
  logic [2*W-1:0] dbl;
  logic [2*W-1:0] dbl_sh;

  always_comb begin
    // rotate: shift doubled word, keep low half
    dbl    = rot_i ? {data_i, data_i} : {{W{1'b0}}, data_i};
    dbl_sh = dbl >> amt_i;
    data_o = dbl_sh[W-1:0];
  end
endmodule

// File: rtl/sigma_lane.sv
module sigma_lane import sigma_pkg::*; #(
  parameter int W  = 32,
  parameter int AW = $clog2(W)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [W-1:0]                   data_i,
  input  logic                           triple_i,
  input  logic [NUM_STAGES-1:0][AW-1:0]  amt_i,
  input  logic [NUM_STAGES-1:0]          rot_i,
  output logic [W-1:0]                   res_o
);
  logic [NUM_STAGES-1:0][W-1:0] st_out;

  for (genvar k = 0; k < NUM_STAGES; k++) begin : g_stage
    sigma_shift_stage #(.W(W), .AW(AW)) i_stage (
      .data_i (data_i),
      .amt_i  (amt_i[k]),
      .rot_i  (rot_i[k]),
      .data_o (st_out[k])
    );

    assert_zero_pass_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (amt_i[k] == '0) |-> (st_out[k] == data_i));
    assert_lsr_fill_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!rot_i[k] && amt_i[k] != '0) |-> (st_out[k][W-1] == 1'b0));
    assert_rot_ones_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rot_i[k] |-> ($countones(st_out[k]) == $countones(data_i)));
  end

  always_comb begin
    res_o = st_out[0];
    if (triple_i) res_o = st_out[0] ^ st_out[1] ^ st_out[2];
  end
endmodule

// File: rtl/sigma_rotxor_unit.sv
module sigma_rotxor_unit import sigma_pkg::*; #(
  parameter int LANE_W = 32
) (
  input  logic                                          clk_i,
  input  logic                                          rst_ni,
  input  logic                                          valid_i,
  input  logic                                          mode_i,
  input  logic                                          func_i,
  input  logic [NUM_STAGES-1:0][$clog2(2*LANE_W)-1:0]   amt_i,
  input  logic [NUM_STAGES-1:0]                         rot_i,
  input  logic [2*LANE_W-1:0]                           data_i,
  output logic                                          valid_o,
  output logic [2*LANE_W-1:0]                           data_o
);
  localparam int WORD_W    = 2 * LANE_W;
  localparam int LANE_AW   = $clog2(LANE_W);
  localparam int WORD_AW   = $clog2(WORD_W);
  localparam int NUM_LANES = WORD_W / LANE_W;

  logic                                 triple;
  logic                                 wide;
  logic [NUM_STAGES-1:0][LANE_AW-1:0]   lane_amt;
  logic [NUM_LANES-1:0][LANE_W-1:0]     lane_res;
  logic [WORD_W-1:0]                    wide_res;
  logic [WORD_W-1:0]                    res_d;

  assign triple = (func_e'(func_i) == FN_TRIPLE);
  assign wide   = (lane_mode_e'(mode_i) == MODE_WIDE);

  always_comb begin
    for (int k = 0; k < NUM_STAGES; k++) lane_amt[k] = amt_i[k][LANE_AW-1:0];
  end

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    sigma_lane #(.W(LANE_W), .AW(LANE_AW)) i_lane (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .data_i   (data_i[g*LANE_W +: LANE_W]),
      .triple_i (triple),
      .amt_i    (lane_amt),
      .rot_i    (rot_i),
      .res_o    (lane_res[g])
    );
  end

  sigma_lane #(.W(WORD_W), .AW(WORD_AW)) i_wide (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .data_i   (data_i),
    .triple_i (triple),
    .amt_i    (amt_i),
    .rot_i    (rot_i),
    .res_o    (wide_res)
  );

  assign res_d = wide ? wide_res : lane_res;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) data_o <= res_d;
    end
  end

  assert_valid_follow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  assert_valid_drop_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  assert_idle_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(data_o));
  assert_lane_isolation_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !mode_i && data_i[WORD_W-1:LANE_W] == '0) |=> (data_o[WORD_W-1:LANE_W] == '0));
endmodule

// File: tb/test_sigma_rotxor_unit.sv
module test_sigma_rotxor_unit;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic valid_i = 1'b0;
  logic mode_i = 1'b0;
  logic func_i = 1'b0;
  logic [2:0][5:0] amt_i = '0;
  logic [2:0] rot_i = '0;
  logic [63:0] data_i = '0;
  logic valid_o;
  logic [63:0] data_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  typedef struct {
    logic [63:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];

  always #2.5 clk_i = ~clk_i;

  sigma_rotxor_unit i_sigma_rotxor_unit (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .mode_i(mode_i),
    .func_i(func_i), .amt_i(amt_i), .rot_i(rot_i), .data_i(data_i),
    .valid_o(valid_o), .data_o(data_o)
  );

  function automatic logic [63:0] shw(logic [63:0] d, int w, int n, bit r);
    logic [63:0] m;
    m = (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
    d = d & m;
    if (n == 0) return d;
    if (r) return ((d >> n) | (d << (w - n))) & m;
    return d >> n;
  endfunction

  function automatic logic [63:0] lane(logic [63:0] d, int w, bit t, int a0, int a1, int a2, logic [2:0] r);
    logic [63:0] v;
    v = shw(d, w, a0, r[0]);
    if (t) v = v ^ shw(d, w, a1, r[1]) ^ shw(d, w, a2, r[2]);
    return v;
  endfunction

  function automatic logic [63:0] model(logic [63:0] d, bit wd, bit t, int a0, int a1, int a2, logic [2:0] r);
    if (wd) return lane(d, 64, t, a0, a1, a2, r);
    return {lane(d[63:32], 32, t, a0 % 32, a1 % 32, a2 % 32, r)[31:0],
            lane(d[31:0], 32, t, a0 % 32, a1 % 32, a2 % 32, r)[31:0]};
  endfunction

  function automatic logic [31:0] rr32(logic [31:0] x, int n);
    return (x >> n) | (x << (32 - n));
  endfunction

  function automatic logic [63:0] rr64(logic [63:0] x, int n);
    return (x >> n) | (x << (64 - n));
  endfunction

  function automatic logic [31:0] rl32(logic [31:0] x, int n);
    return (x << n) | (x >> (32 - n));
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic send(logic [63:0] d, bit wd, bit t, int a0, int a1, int a2,
                      logic [2:0] r, logic [63:0] exp, string tag);
    @(negedge clk_i);
    valid_i = 1'b1; mode_i = wd; func_i = t;
    amt_i = {6'(a2), 6'(a1), 6'(a0)}; rot_i = r; data_i = d;
    sb.push_back('{exp, tag});
  endtask

  task automatic idle();
    @(negedge clk_i);
    valid_i = 1'b0;
    data_i = ~data_i; amt_i = ~amt_i;
  endtask

  // monitor: pop and compare
  always @(negedge clk_i) begin
    if (rst_ni && valid_o) begin
      if (sb.size() == 0) check("R2 unexpected valid_o", 64'(valid_o), 64'd0);
      else begin
        item_t it;
        it = sb.pop_front();
        check(it.tag, data_o, it.exp);
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : driver
    logic [63:0] d, held;
    logic [31:0] hi, lo;
    #1;
    check("R1 reset valid_o", 64'(valid_o), 64'd0);
    check("R1 reset data_o", data_o, 64'd0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    d = 64'h8123_4567_F0E1_D2C3;
    send(d, 0, 0, 8, 0, 0, 3'b001, model(d, 0, 0, 8, 0, 0, 3'b001), "R5 split rotate");
    send(d, 0, 0, 9, 0, 0, 3'b000, {32'h8123_4567 >> 9, 32'hF0E1_D2C3 >> 9}, "R5 split logical");
    send(d, 0, 0, 5, 17, 30, 3'b111, model(d, 0, 0, 5, 0, 0, 3'b001), "R3 single ignores stages 1,2");
    send(d, 0, 1, 3, 11, 19, 3'b101, model(d, 0, 1, 3, 11, 19, 3'b101), "R4 triple mixed types");
    send(64'h0000_0000_FFFF_FFFF, 0, 1, 1, 7, 13, 3'b011,
         {32'h0, model(64'hFFFF_FFFF, 0, 1, 1, 7, 13, 3'b011)[31:0]}, "R6 lane isolation");
    send(d, 0, 0, 36, 0, 0, 3'b001, model(d, 0, 0, 4, 0, 0, 3'b001), "R7 split drops amt bit5");
    send(d, 1, 0, 40, 0, 0, 3'b001, rr64(d, 40), "R8 wide rotate 40");
    send(d, 1, 0, 63, 0, 0, 3'b000, d >> 63, "R8 wide logical 63");
    send(d, 0, 0, 0, 0, 0, 3'b000, d, "R9 zero amount split");
    send(d, 1, 0, 0, 0, 0, 3'b001, d, "R9 zero amount wide");
    send(d, 0, 0, 32 - 7, 0, 0, 3'b001, {rl32(d[63:32], 7), rl32(d[31:0], 7)}, "R10 left rotate via 32-n");
    hi = 32'h6A09_E667; lo = 32'hBB67_AE85;
    send({hi, lo}, 0, 1, 2, 13, 22, 3'b111,
         {rr32(hi, 2) ^ rr32(hi, 13) ^ rr32(hi, 22), rr32(lo, 2) ^ rr32(lo, 13) ^ rr32(lo, 22)},
         "R11 sigma256 big0 both lanes");
    d = 64'h510E_527F_ADE6_82D1;
    send(d, 1, 1, 14, 18, 41, 3'b111, rr64(d, 14) ^ rr64(d, 18) ^ rr64(d, 41), "R11 sigma512 big1");
    idle();
    @(negedge clk_i);
    held = data_o;
    idle(); idle();
    @(negedge clk_i);
    check("R2 idle valid_o low", 64'(valid_o), 64'd0);
    check("R2 idle data_o held", data_o, held);
    check("R2 scoreboard drained", 64'(sb.size()), 64'd0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule